// File: doc/BRIEF.md
# Modulo Timer with Capture, Compare and Buffered PWM

A 16-bit up-counter runs from zero to a software-programmed limit and then starts again from zero. Each pass through the limit is an overflow. The counter is stepped by the bus clock divided by a power of two, or by rising edges of an external clock pin. That pin is sampled in the bus clock domain. Two channels watch the counter. Each channel works on its own in one of two modes. In capture mode it latches the count on a rising edge of its input. In compare mode it toggles its output when the count matches its value. Channel 0 can also claim channel 1 as a partner. The pair then produces one PWM waveform whose duty value comes from the two channel value registers, and the active register alternates at each overflow.

Software works through a flat word-wide register file with seven addresses. A flag is cleared in two steps: the status is read while the flag is set, and then a 0 is written to the flag bit. The overflow event and each channel event can each raise a gated interrupt. While a wait input is held high, the timer keeps running, the register file is closed, and any enabled interrupt drives a wake-up output.

Top module: `modtimer`

## Requirements
- R1: After reset the status/control word (address 0) reads 0x0020: counter stopped, divide code 0, flags and enables clear. All outputs are low.
- R2: The status/control word has the flag in bit 7, the enable in bit 6, stop in bit 5, clear in bit 4 and the divide code in bits 2:0. Divide codes 0 to 6 advance the count (address 1) once every 2^code bus cycles.
- R3: On a step where the count equals the limit (address 2), the count returns to 0 and the overflow flag is set.
- R4: The overflow interrupt output is high exactly while both the overflow flag and its enable are set.
- R5: A flag is cleared only by a write of 0 to it that follows a read of its control word taken while the flag was set. A write without such a read leaves the flag set. Writing a 1 to a flag bit has no effect.
- R6: Divide code 7 steps the count once per synchronized rising edge of the external clock pin. While that code is selected, clk_pin_is_input is high, and the count holds while the pin is idle.
- R7: The stop bit halts the count. Writing 1 to the clear bit zeroes the count and the divider; the clear bit always reads 0.
- R8: In capture mode (channel control bit 5 = 0), a rising edge on the channel input, after a two-stage synchronizer, latches the count into the channel value register and sets the channel flag. Channel 0 uses control address 3 and value address 4; channel 1 uses control address 5 and value address 6.
- R9: In compare mode (control bit 5 = 1), a step taken while the count equals the channel value toggles the channel output and sets the channel flag (control bit 7).
- R10: Each channel interrupt output is its flag gated by its enable (control bit 6). Channel flags clear by the R5 sequence.
- R11: Setting bit 4 of channel 0 control selects paired PWM. Output 0 rises at each overflow and falls when the count matches the active value register. The active register is channel 0 after a clear and swaps at each overflow. Output 1 is held low.
- R12: While wait is high, writes are ignored, reads return 0, the count continues, and wake is high when any interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wait_i | input | 1 | Low-power standby request |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data; 0 when not reading |
| ext_clk | input | 1 | External count clock pin |
| clk_pin_is_input | output | 1 | Forces the clock pin to act as an input |
| ch_in | input | 2 | Channel capture inputs |
| ch_out | output | 2 | Channel compare / PWM outputs |
| ch_irq | output | 2 | Channel interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt request |
| wake | output | 1 | Wake-up request during wait |

## Verification
The assertions assume that the external clock pin and the channel inputs hold each level for at least two bus cycles, so that every rising edge passes the synchronizer. The bench drives them in pulses of four cycles or more. The assertions also assume that software changes the limit only while the counter is stopped. The bench writes the limit and the compare values either with the count stopped, or, in paired mode, only into the inactive value register.

// File: rtl/modtimer.sv
module modtimer #(
  parameter int CW    = 16,
  parameter int PSMAX = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_i,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [2:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic          ext_clk,
  output logic          clk_pin_is_input,
  input  logic [1:0]    ch_in,
  output logic [1:0]    ch_out,
  output logic [1:0]    ch_irq,
  output logic          ovf_irq,
  output logic          wake
);
  localparam int PREW = PSMAX;

  logic we, re, ext_sel, ext_rise, tick, clr, wrap;
  logic [PREW-1:0] pre, mask;
  logic [CW-1:0] cnt, modv, act;
  logic [CW-1:0] cv [2];
  logic [2:0] cin [2];
  logic [2:0] ps, ex;
  logic stop, ovf_f, ovf_ie, ovf_arm, pair, abuf;
  logic [1:0] ch_f, ch_ie, ch_md, ch_arm, outq, ev, rise, cmp;

  assign we       = reg_we & !wait_i;
  assign re       = reg_re & !wait_i;
  assign ext_sel  = (ps == 3'd7);
  assign mask     = ext_sel ? '0 : PREW'((32'd1 << ps) - 32'd1);
  assign ext_rise = ex[1] & ~ex[2];
  assign tick     = !stop && (ext_sel ? ext_rise : ((pre & mask) == mask));
  assign clr      = we && reg_addr == 3'd0 && reg_wdata[4];
  assign wrap     = tick && (cnt == modv);
  assign act      = abuf ? cv[1] : cv[0];

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_ch
      assign rise[g] = cin[g][1] & ~cin[g][2];
      assign cmp[g]  = tick && (cnt == cv[g]);
      assign ev[g]   = pair ? (tick && cnt == act && abuf == 1'(g))
                            : (ch_md[g] ? cmp[g] : rise[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; cnt <= '0; modv <= '1; ps <= '0; stop <= 1'b1;
      ovf_f <= 1'b0; ovf_ie <= 1'b0; ovf_arm <= 1'b0;
      ex <= '0; pair <= 1'b0; abuf <= 1'b0;
    end else begin
      ex <= {ex[1:0], ext_clk};
      if (clr) begin
        pre <= '0;
        cnt <= '0;
      end else if (!stop) begin
        pre <= pre + 1'b1;
        if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
      end
      if (we && reg_addr == 3'd2) modv <= reg_wdata;
      if (we && reg_addr == 3'd0) begin
        ovf_ie <= reg_wdata[6];
        stop   <= reg_wdata[5];
        ps     <= reg_wdata[2:0];
      end
      if (wrap) ovf_f <= 1'b1;
      else if (we && reg_addr == 3'd0 && !reg_wdata[7] && ovf_arm) ovf_f <= 1'b0;
      if (re && reg_addr == 3'd0 && ovf_f) ovf_arm <= 1'b1;
      else if (we && reg_addr == 3'd0) ovf_arm <= 1'b0;
      if (we && reg_addr == 3'd3) pair <= reg_wdata[4];
      if (clr || !pair) abuf <= 1'b0;
      else if (wrap) abuf <= ~abuf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        cin[i] <= '0;
        cv[i]  <= '0;
      end
      ch_f <= '0; ch_ie <= '0; ch_md <= '0; ch_arm <= '0; outq <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        cin[i] <= {cin[i][1:0], ch_in[i]};
        if (we && reg_addr == 3'(3 + 2 * i)) begin
          ch_ie[i] <= reg_wdata[6];
          ch_md[i] <= reg_wdata[5];
        end
        if (!pair && !ch_md[i] && rise[i]) cv[i] <= cnt;
        else if (we && reg_addr == 3'(4 + 2 * i)) cv[i] <= reg_wdata;
        if (ev[i]) ch_f[i] <= 1'b1;
        else if (we && reg_addr == 3'(3 + 2 * i) && !reg_wdata[7] && ch_arm[i]) ch_f[i] <= 1'b0;
        if (re && reg_addr == 3'(3 + 2 * i) && ch_f[i]) ch_arm[i] <= 1'b1;
        else if (we && reg_addr == 3'(3 + 2 * i)) ch_arm[i] <= 1'b0;
        if (pair) begin
          if (i == 1) outq[i] <= 1'b0;
          else if (wrap) outq[i] <= 1'b1;
          else if (|ev) outq[i] <= 1'b0;
        end else if (ch_md[i] && cmp[i]) begin
          outq[i] <= ~outq[i];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (re) begin
      case (reg_addr)
        3'd0: reg_rdata = CW'({ovf_f, ovf_ie, stop, 2'b00, ps});
        3'd1: reg_rdata = cnt;
        3'd2: reg_rdata = modv;
        3'd3: reg_rdata = CW'({ch_f[0], ch_ie[0], ch_md[0], pair, 4'b0000});
        3'd4: reg_rdata = cv[0];
        3'd5: reg_rdata = CW'({ch_f[1], ch_ie[1], ch_md[1], 5'b00000});
        3'd6: reg_rdata = cv[1];
        default: reg_rdata = '0;
      endcase
    end
  end

  assign clk_pin_is_input = ext_sel;
  assign ch_out  = outq;
  assign ch_irq  = ch_f & ch_ie;
  assign ovf_irq = ovf_f & ovf_ie;
  assign wake    = wait_i & (ovf_irq | (|ch_irq));

  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !clr) |=> (cnt == '0 && ovf_f));

  // R6
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && !stop && !ext_rise && !clr) |=> $stable(cnt));

  // R12
  wait_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_i && reg_we && reg_addr == 3'd2) |=> $stable(modv));

  // R8
  chflag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_f[0]) |-> $past(ev[0]));

  // R11
  pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair && $past(pair) && $rose(ch_out[0])) |-> $past(wrap));
endmodule

// File: tb/test_modtimer.sv
`timescale 1ns/1ps
module test_modtimer;
  logic clk = 1'b0, rst_n = 1'b0, wait_i = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0, ext_clk = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic clk_pin_is_input, ovf_irq, wake;
  logic [1:0] ch_in = '0, ch_out, ch_irq;
  int errs = 0, checks = 0;
  bit done = 0;

  localparam int NV = 7;
  localparam logic [2:0] PS_V [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
  localparam int CYC = 40;
  localparam logic [15:0] EXP_V [NV] = '{16'd40, 16'd20, 16'd10, 16'd5, 16'd2, 16'd1, 16'd0};

  modtimer i_modtimer (.clk(clk), .rst_n(rst_n), .wait_i(wait_i), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_clk(ext_clk), .clk_pin_is_input(clk_pin_is_input), .ch_in(ch_in),
    .ch_out(ch_out), .ch_irq(ch_irq), .ovf_irq(ovf_irq), .wake(wake));

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] d, c1, c2;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    rd(3'd0, d);
    check("R1 status", d, 16'h0020);
    check("R1 outputs", {ch_out, ch_irq, ovf_irq, wake, clk_pin_is_input}, 7'd0);

    wr(3'd2, 16'hFFFF);
    for (int k = 0; k < NV; k++) begin
      wr(3'd0, 16'h0010 | 16'(PS_V[k]));
      idle(CYC);
      rd(3'd1, d);
      check($sformatf("R2 divide code %0d", PS_V[k]), d, EXP_V[k]);
    end

    wr(3'd0, 16'h0020);
    wr(3'd2, 16'd4);
    wr(3'd0, 16'h0010);
    idle(4);
    rd(3'd0, d);
    check("R3 flag before wrap", d, 16'h0000);
    rd(3'd0, d);
    check("R3 flag after wrap", d, 16'h0080);
    wr(3'd0, 16'h00E0);
    check("R4 overflow irq", ovf_irq, 1'b1);
    wr(3'd0, 16'h0060);
    check("R5 clear without read", ovf_irq, 1'b1);
    rd(3'd0, d);
    check("R5 status", d, 16'h00E0);
    wr(3'd0, 16'h0060);
    check("R5 cleared", ovf_irq, 1'b0);

    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h0040);
    wr(3'd0, 16'h0010);
    ch_in = 2'b01;
    idle(2);
    check("R8 flag latency", ch_irq[0], 1'b0);
    idle(1);
    check("R10 capture irq", ch_irq[0], 1'b1);
    rd(3'd4, d);
    check("R8 captured count", d, 16'd2);

    rd(3'd1, c1);
    wait_i = 1'b1;
    #1 check("R12 wake", wake, 1'b1);
    rd(3'd2, d);
    check("R12 read blocked", d, 16'h0000);
    wr(3'd2, 16'h1234);
    wait_i = 1'b0;
    rd(3'd2, d);
    check("R12 write ignored", d, 16'hFFFF);
    rd(3'd1, c2);
    check("R12 count ran", c2 > c1, 1'b1);

    rd(3'd3, d);
    check("R10 ch0 status", d, 16'h00C0);
    wr(3'd3, 16'h0040);
    check("R10 ch0 cleared", ch_irq[0], 1'b0);

    wr(3'd0, 16'h0020);
    wr(3'd6, 16'd3);
    wr(3'd5, 16'h0020);
    wr(3'd0, 16'h0010);
    idle(3);
    check("R9 before match", ch_out[1], 1'b0);
    idle(1);
    check("R9 toggled", ch_out[1], 1'b1);
    rd(3'd5, d);
    check("R9 ch1 flag", d, 16'h00A0);
    check("R10 ch1 irq gated", ch_irq[1], 1'b0);

    wr(3'd0, 16'h0020);
    rd(3'd1, c1);
    idle(5);
    rd(3'd1, c2);
    check("R7 stopped", c2, c1);
    wr(3'd0, 16'h0030);
    rd(3'd1, d);
    check("R7 clear", d, 16'h0000);
    rd(3'd0, d);
    check("R7 clear bit reads 0", d, 16'h0020);

    wr(3'd0, 16'h0017);
    check("R6 pin input", clk_pin_is_input, 1'b1);
    idle(10);
    rd(3'd1, d);
    check("R6 idle pin", d, 16'h0000);
    for (int p = 0; p < 3; p++) begin
      ext_clk = 1'b1; idle(4);
      ext_clk = 1'b0; idle(4);
    end
    idle(4);
    rd(3'd1, d);
    check("R6 edge count", d, 16'd3);

    wr(3'd0, 16'h0020);
    wr(3'd2, 16'd9);
    wr(3'd4, 16'd3);
    wr(3'd6, 16'd6);
    wr(3'd3, 16'h0030);
    wr(3'd0, 16'h0010);
    idle(9);
    check("R11 low first period", ch_out[0], 1'b0);
    idle(1);
    check("R11 rise at wrap", ch_out[0], 1'b1);
    check("R11 out1 held low", ch_out[1], 1'b0);
    wr(3'd4, 16'd5);
    idle(5);
    check("R11 high before ch1 match", ch_out[0], 1'b1);
    idle(1);
    check("R11 fall at ch1 value", ch_out[0], 1'b0);
    idle(3);
    check("R11 second wrap", ch_out[0], 1'b1);
    idle(5);
    check("R11 old value unused", ch_out[0], 1'b1);
    idle(1);
    check("R11 new value next period", ch_out[0], 1'b0);

    finish_run();
  end
endmodule